// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts the direction of conditional branches. It combines two predictors with a third. The first is a per-branch predictor with two levels: a table of per-branch outcome histories selects a 2-bit counter. The second is a correlating predictor, where the shared history of recent outcomes selects a 2-bit counter. A third table of 2-bit selector counters learns, for each global-history context, which of the two has been right more often. The selector then steers a multiplexer between their directions. Some branches follow their own past and others follow their neighbours, and the selector lets each context use the predictor that suits it.

The predict side is purely combinational. A PC goes in, and the final direction comes out together with both component directions. The fetch logic keeps the two component directions with the branch. When the branch resolves, they are presented again on the update side with the PC and the real outcome. On that clock edge, the block trains both component counters and trains the selector when the components disagreed. It also shifts the outcome into the branch's own history and into the global history. Target prediction, return-address handling and recovery of speculative history are not part of this block.

Top module: `tourn_bp`

## Requirements
- R1: After reset every component counter holds 1, every selector counter holds 1 (weak preference for the per-branch side), and all histories are zero. All three predictions are therefore not-taken for any PC until the first update.
- R2: All counters are 2-bit saturating counters. A taken outcome adds 1 up to a limit of 3, and a not-taken outcome subtracts 1 down to a limit of 0. A counter value of 2 or 3 means taken.
- R3: The per-branch side holds 1024 histories of 10 bits, selected by PC bits [11:2]. The selected history directly addresses one of 1024 counters, and `pred_local` is that counter's taken decision.
- R4: The global side holds a 12-bit history that directly addresses one of 4096 counters, and `pred_global` is that counter's decision. On each update the outcome enters both the global history and the branch's own history at bit 0, and the older bits move up by one.
- R5: The selector counter is addressed by the same 12-bit global history. A value of 2 or more makes `pred_taken` equal `pred_global`; otherwise `pred_taken` equals `pred_local`.
- R6: The selector counter at the current global history changes only when `upd_local` differs from `upd_global`. It counts up when `upd_global` equals `upd_taken` and counts down otherwise.
- R7: Training uses the histories held at the time of the update to address the counters. It uses the component directions supplied on the update port, even when these do not match what the tables would now predict.
- R8: When a prediction and an update happen in the same cycle, the prediction reflects the state before the update. The update's effect is visible from the next cycle.
- R9: While `upd_valid` is low, no counter and no history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Final direction after selection |
| pred_local | output | 1 | Per-branch component direction |
| pred_global | output | 1 | Global component direction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local | input | 1 | Per-branch direction given at prediction time |
| upd_global | input | 1 | Global direction given at prediction time |

## Verification
The predict lookup and the training write can land in the same cycle and hit the same entries. The bench provokes this by predicting the very PC that is being updated, with the same history still in place, on every cycle of a loop pattern. Its scoreboard model computes each expected prediction from its state before applying that cycle's update at the edge. A design that forwards the write into the read, or lags by one more cycle, therefore disagrees with the model. A random phase then feeds arbitrary, often inconsistent, component directions to the update port to exercise selector training and the case where the components agree. A final phase holds `upd_valid` low with noisy update fields.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr_t;

  // saturating step of a 2-bit counter
  function automatic ctr_t ctr_next(input ctr_t cur, input logic up);
    ctr_t res;
    if (up) res = (cur == 2'd3) ? cur : cur + 2'd1;
    else    res = (cur == 2'd0) ? cur : cur - 2'd1;
    return res;
  endfunction

  function automatic logic ctr_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int   IDX_W = 10,
  parameter ctr_t INIT  = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t wr_old;

  assign rd_ctr = mem[rd_idx];
  assign wr_old = mem[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_next(wr_old, wr_up);
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_old == 2'd3) |=> mem[$past(wr_idx)] == 2'd3); // R2
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_old == 2'd0) |=> mem[$past(wr_idx)] == 2'd0); // R2

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic [HIST_W-1:0] wr_hist,
  input  logic              wr_en,
  input  logic              wr_bit
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];
  assign wr_hist = mem[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {wr_hist[HIST_W-2:0], wr_bit};
    end
  end

  AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == {$past(wr_hist[HIST_W-2:0]), $past(wr_bit)}); // R4

endmodule

// File: rtl/tourn_bp.sv
module tourn_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GHIST_W   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);

  localparam int PC_LO = 2;
  localparam int PC_HI = PC_LO + LHT_IDX_W - 1;

  logic [LHT_IDX_W-1:0] pred_slot, upd_slot;
  logic [LHIST_W-1:0]   lhist_pred, lhist_upd;
  logic [GHIST_W-1:0]   ghist;
  ctr_t                 lctr_rd, gctr_rd, sel_rd;
  logic                 use_global;
  logic                 comps_differ, sel_wr, sel_up;
  logic                 unused_pc_bits;

  assign pred_slot = pred_pc[PC_HI:PC_LO];
  assign upd_slot  = upd_pc[PC_HI:PC_LO];
  assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_HI+1], pred_pc[PC_LO-1:0],
                            upd_pc[PC_W-1:PC_HI+1], upd_pc[PC_LO-1:0]};

  // per-branch histories
  tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_slot), .rd_hist(lhist_pred),
    .wr_idx(upd_slot), .wr_hist(lhist_upd),
    .wr_en(upd_valid), .wr_bit(upd_taken)
  );

  // per-branch counters addressed by the branch's history
  tbp_ctr_table #(.IDX_W(LHIST_W), .INIT(2'd1)) u_lctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lhist_pred), .rd_ctr(lctr_rd),
    .wr_en(upd_valid), .wr_idx(lhist_upd), .wr_up(upd_taken)
  );

  // global counters addressed by global history
  tbp_ctr_table #(.IDX_W(GHIST_W), .INIT(2'd1)) u_gctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_ctr(gctr_rd),
    .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
  );

  // selector: trained only on disagreement, toward the side that was right
  assign comps_differ = upd_local ^ upd_global;
  assign sel_wr       = upd_valid && comps_differ;
  assign sel_up       = (upd_global == upd_taken);

  tbp_ctr_table #(.IDX_W(GHIST_W), .INIT(2'd1)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_ctr(sel_rd),
    .wr_en(sel_wr), .wr_idx(ghist), .wr_up(sel_up)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ghist <= '0;
    else if (upd_valid) ghist <= {ghist[GHIST_W-2:0], upd_taken};
  end

  assign pred_local  = ctr_taken(lctr_rd);
  assign pred_global = ctr_taken(gctr_rd);
  assign use_global  = ctr_taken(sel_rd);
  assign pred_taken  = use_global ? pred_global : pred_local;

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)}); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist)); // R9
  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local)); // R5
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_local == upd_global) |-> !sel_wr); // R6

endmodule

// File: tb/tourn_bp_bench.sv
module tourn_bp_bench;

  localparam int  PC_W  = 32;
  localparam int  LDEP  = 1024;
  localparam int  GDEP  = 4096;
  localparam time HALF  = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken, pred_local, pred_global;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;

  always #HALF clk = ~clk;

  tourn_bp u_tourn_bp (
    .clk(clk), .rst_n(rst_n),
    .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_local(upd_local), .upd_global(upd_global)
  );

  // ---------------- reference model ----------------
  int m_lht [LDEP];
  int m_lctr[LDEP];
  int m_gctr[GDEP];
  int m_sel [GDEP];
  int m_gh;

  function automatic int slot_of(input logic [PC_W-1:0] pc);
    return int'((pc / 4) % LDEP);
  endfunction

  function automatic bit m_loc(input logic [PC_W-1:0] pc);
    return m_lctr[m_lht[slot_of(pc)]] > 1;
  endfunction

  function automatic bit m_glb();
    return m_gctr[m_gh] > 1;
  endfunction

  function automatic bit m_fin(input logic [PC_W-1:0] pc);
    return (m_sel[m_gh] > 1) ? m_glb() : m_loc(pc);
  endfunction

  function automatic int bump(input int v, input bit up);
    if (up) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < LDEP; i++) begin m_lht[i] = 0; m_lctr[i] = 1; end
    for (int i = 0; i < GDEP; i++) begin m_gctr[i] = 1; m_sel[i] = 1; end
    m_gh = 0;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input bit t, input bit l, input bit g);
    int s;
    s = slot_of(pc);
    m_lctr[m_lht[s]] = bump(m_lctr[m_lht[s]], t);
    m_gctr[m_gh]     = bump(m_gctr[m_gh], t);
    if (l != g) m_sel[m_gh] = bump(m_sel[m_gh], g == t);
    m_lht[s] = ((m_lht[s] * 2) + int'(t)) % LDEP;
    m_gh     = ((m_gh * 2) + int'(t)) % GDEP;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    bit    fin;
    bit    loc;
    bit    glb;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;
  int   checks = 0;
  int   fails  = 0;

  task automatic check_bit(input string tag, input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s got %0b expected %0b at %0t", req, tag, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8 scoreboard empty got 0 expected 1 items");
      end else begin
        e = exp_q.pop_front();
        check_bit(e.tag, "R3 local", pred_local, e.loc);
        check_bit(e.tag, "R4 global", pred_global, e.glb);
        check_bit(e.tag, "R5 final", pred_taken, e.fin);
      end
    end
  end

  // driver: predict p this cycle, optionally update; model moves at the edge (R8)
  task automatic step(input logic [PC_W-1:0] p, input bit v, input logic [PC_W-1:0] up,
                      input bit t, input bit l, input bit g, input string tag);
    exp_t e;
    @(negedge clk);
    pred_pc = p; upd_valid = v; upd_pc = up;
    upd_taken = t; upd_local = l; upd_global = g;
    e.fin = m_fin(p); e.loc = m_loc(p); e.glb = m_glb(); e.tag = tag;
    exp_q.push_back(e);
    #2 ->mon_ev;
    @(posedge clk);
    #1;
    if (v) model_update(up, t, l, g);
  endtask

  // update with the component directions the model would have given
  task automatic train(input logic [PC_W-1:0] pc, input bit t, input string tag);
    step(pc, 1'b1, pc, t, m_loc(pc), m_glb(), tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    checks++; fails++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] pcs [8];
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: all predictions start not-taken
    step(32'h0000_0100, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1 reset");
    step(32'h0000_0ffc, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1 reset");
    step(32'hdead_beec, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1 reset");

    // R2/R8: repeated taken saturates; predict same PC while it is updated
    repeat (20) train(32'h0000_0100, 1'b1, "R2 R8 saturate-up");
    repeat (20) train(32'h0000_0100, 1'b0, "R2 R8 saturate-down");

    // R3/R6: loop pattern, nine taken then one not-taken
    for (int it = 0; it < 30; it++)
      for (int k = 0; k < 10; k++)
        train(32'h0000_0200, k != 9, "R3 R6 loop");

    // R4/R6: two interleaved branches correlated by global history
    for (int it = 0; it < 60; it++) begin
      train(32'h0000_0300, it % 2 == 0, "R4 R6 corr-a");
      train(32'h0000_0404, it % 2 == 0, "R4 R6 corr-b");
    end

    // R7/R6: arbitrary component directions on the update port
    for (int i = 0; i < 8; i++) pcs[i] = 32'h0000_1000 + 32'(i * 4) + 32'(i * 32'h1000);
    for (int i = 0; i < 800; i++) begin
      logic [PC_W-1:0] a, b;
      a = pcs[$urandom % 8];
      b = pcs[$urandom % 8];
      step(a, 1'b1, b, 1'($urandom), 1'($urandom), 1'($urandom), "R7 R6 random");
    end

    // R9: update fields toggle but valid is low
    for (int i = 0; i < 40; i++)
      step(pcs[i % 8], 1'b0, pcs[(i + 3) % 8], 1'($urandom), 1'($urandom), 1'($urandom), "R9 idle");

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule